// File: doc/BRIEF.md
# Coherent Time-Register Read/Write Buffer

This block sits between a byte-wide host transfer engine and the live timekeeping counters of a real-time clock. Reads are never served straight from the counters. They come from a bank of user-side copies, so a host reading several time bytes in a row sees one coherent instant even if the one-second update fires during the transfer. The copies are refreshed only at defined moments: when a transfer begins, when it ends, and when the register pointer steps past the last time register and rolls back to address zero.

The block owns the auto-incrementing register pointer. The host engine can load the pointer with an address byte. It signals that a read byte was consumed, or that a written byte was acknowledged, and each such event advances the pointer. A written byte is committed to the counters at its acknowledge event through a one-hot write strobe and a data byte. The same byte also replaces the user copy of that register, so an immediate read-back returns what was written. Decoding of the serial bit protocol happens elsewhere.

Top module: `rtc_shadow_buffer`

## Requirements
- R1: During and after synchronous reset, the pointer, every user copy, `rd_data_o`, `cnt_we_o` and `cnt_wdata_o` are all zero.
- R2: In a cycle with `start_i` high, every user copy is loaded from `live_i` as sampled at that clock edge.
- R3: In a cycle with `stop_i` high, every user copy is loaded from `live_i` as sampled at that clock edge.
- R4: Each `rd_ack_i` or `wr_ack_i` advances `ptr_o` by one at the next edge. From address NREGS-1 it goes to 0. With no ack and no load, `ptr_o` holds.
- R5: An ack that moves the pointer from NREGS-1 to 0 also loads every user copy from `live_i` at that edge.
- R6: Changes on `live_i` outside the snapshot cycles of R2, R3 and R5 leave the user copies, and so `rd_data_o`, unchanged.
- R7: The cycle after `wr_ack_i`, `cnt_we_o` has exactly one bit set, at the pointer value of the ack cycle, and `cnt_wdata_o` equals that cycle's `wr_data_i`. In every other cycle both outputs are zero.
- R8: An acknowledged write also stores `wr_data_i` in the user copy at the pointer. This takes priority over a snapshot in the same cycle.
- R9: `ptr_load_i` sets the pointer to `ptr_val_i` when that value is below NREGS, and to 0 otherwise. A load never triggers a snapshot.
- R10: `rd_data_o` is a register that, one cycle after each edge, shows the user copy selected by the pointer as they stood after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer-begin event pulse |
| stop_i | input | 1 | Transfer-end event pulse |
| ptr_load_i | input | 1 | Load the pointer from `ptr_val_i` |
| ptr_val_i | input | DW | Address byte for a pointer load |
| rd_ack_i | input | 1 | A read byte was consumed; advance the pointer |
| wr_ack_i | input | 1 | The written byte is acknowledged; commit it and advance |
| wr_data_i | input | DW | Byte being written |
| live_i | input | NREGS*DW | Live counter values, register k at bits k*DW upward |
| ptr_o | output | AW | Current register pointer |
| rd_data_o | output | DW | Registered read byte from the user copies |
| cnt_we_o | output | NREGS | One-hot write strobe toward the counters |
| cnt_wdata_o | output | DW | Data accompanying `cnt_we_o` |

## Verification
The pointer properties assume that `ptr_load_i`, `rd_ack_i` and `wr_ack_i` are mutually exclusive within a cycle, since the host engine issues one byte-level event at a time. `start_i` and `stop_i` may coincide with any of them. The stimulus picks at most one of the three per cycle, both in the directed phases and in the pseudo-random phase. It lets start and stop overlap freely, and it varies `live_i` on nearly every cycle so that snapshot timing can be seen.

// File: rtl/rtc_shadow_pkg.sv
`timescale 1ns/1ps
package rtc_shadow_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_LOAD = 2'd1,
    PTR_STEP = 2'd2
  } ptr_op_e;
endpackage

// File: rtl/rsb_ptr_unit.sv
`timescale 1ns/1ps
module rsb_ptr_unit
  import rtc_shadow_pkg::*;
#(
  parameter int NREGS = 7,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  ptr_op_e       op,
  input  logic [DW-1:0] load_val,
  output logic [AW-1:0] ptr_q,
  output logic          wrap
);
  localparam logic [AW-1:0] LAST = AW'(NREGS - 1);

  logic          in_range;
  logic [AW-1:0] ptr_d;

  assign in_range = (32'(load_val) < NREGS);
  assign wrap     = (op == PTR_STEP) && (ptr_q == LAST);

  always_comb begin
    ptr_d = ptr_q;
    case (op)
      PTR_LOAD: ptr_d = in_range ? load_val[AW-1:0] : '0;
      PTR_STEP: ptr_d = (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
      default:  ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end
endmodule

// File: rtl/rsb_shadow_bank.sv
`timescale 1ns/1ps
module rsb_shadow_bank #(
  parameter int NREGS = 7,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                snap,
  input  logic [NREGS*DW-1:0] live,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic [AW-1:0]       rd_idx,
  output logic [DW-1:0]       rd_data_q
);
  logic [DW-1:0] copy_q [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) copy_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++) begin
        if (wr_en && (wr_idx == AW'(i))) copy_q[i] <= wr_data;
        else if (snap)                   copy_q[i] <= live[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_q <= '0;
    else     rd_data_q <= copy_q[rd_idx];
  end
endmodule

// File: rtl/rsb_commit.sv
`timescale 1ns/1ps
module rsb_commit #(
  parameter int NREGS = 7,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic [AW-1:0]    idx,
  input  logic [DW-1:0]    data,
  output logic [NREGS-1:0] we_q,
  output logic [DW-1:0]    wdata_q
);
  logic [NREGS-1:0] dec;

  for (genvar g = 0; g < NREGS; g++) begin : g_dec
    assign dec[g] = ack && (idx == AW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= '0;
      wdata_q <= '0;
    end else begin
      we_q    <= dec;
      wdata_q <= ack ? data : '0;
    end
  end
endmodule

// File: rtl/rtc_shadow_buffer.sv
`timescale 1ns/1ps
module rtc_shadow_buffer
  import rtc_shadow_pkg::*;
#(
  parameter int NREGS = 7,
  parameter int DW    = 8,
  localparam int AW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                ptr_load_i,
  input  logic [DW-1:0]       ptr_val_i,
  input  logic                rd_ack_i,
  input  logic                wr_ack_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic [NREGS*DW-1:0] live_i,
  output logic [AW-1:0]       ptr_o,
  output logic [DW-1:0]       rd_data_o,
  output logic [NREGS-1:0]    cnt_we_o,
  output logic [DW-1:0]       cnt_wdata_o
);
  ptr_op_e op;
  logic    wrap;
  logic    snap;

  always_comb begin
    if (ptr_load_i)               op = PTR_LOAD;
    else if (rd_ack_i || wr_ack_i) op = PTR_STEP;
    else                          op = PTR_HOLD;
  end

  assign snap = start_i || stop_i || wrap;

  rsb_ptr_unit #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .load_val (ptr_val_i),
    .ptr_q    (ptr_o),
    .wrap     (wrap)
  );

  rsb_shadow_bank #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .snap      (snap),
    .live      (live_i),
    .wr_en     (wr_ack_i),
    .wr_idx    (ptr_o),
    .wr_data   (wr_data_i),
    .rd_idx    (ptr_o),
    .rd_data_q (rd_data_o)
  );

  rsb_commit #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_commit (
    .clk     (clk),
    .rst     (rst),
    .ack     (wr_ack_i),
    .idx     (ptr_o),
    .data    (wr_data_i),
    .we_q    (cnt_we_o),
    .wdata_q (cnt_wdata_o)
  );
endmodule

// File: rtl/rtc_shadow_buffer_chk.sv
`timescale 1ns/1ps
module rtc_shadow_buffer_chk #(
  parameter int NREGS = 7,
  parameter int DW    = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ptr_load_i,
  input logic [DW-1:0]    ptr_val_i,
  input logic             rd_ack_i,
  input logic             wr_ack_i,
  input logic [AW-1:0]    ptr_o,
  input logic [NREGS-1:0] cnt_we_o,
  input logic [DW-1:0]    cnt_wdata_o
);
  localparam logic [AW-1:0] LAST = AW'(NREGS - 1);
  logic step;
  assign step = (rd_ack_i || wr_ack_i) && !ptr_load_i;

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cnt_we_o));

  // R7
  strobe_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ack_i |=> ($countones(cnt_we_o) == 1));

  // R7
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_ack_i |=> (cnt_we_o == '0 && cnt_wdata_o == '0));

  // R4
  ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step && ptr_o != LAST) |=> (ptr_o == $past(ptr_o) + AW'(1)));

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && ptr_o == LAST) |=> (ptr_o == '0));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ptr_load_i && !rd_ack_i && !wr_ack_i) |=> $stable(ptr_o));

  // R9
  ptr_load_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_load_i && 32'(ptr_val_i) >= NREGS) |=> (ptr_o == '0));
endmodule

bind rtc_shadow_buffer rtc_shadow_buffer_chk #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ptr_load_i  (ptr_load_i),
  .ptr_val_i   (ptr_val_i),
  .rd_ack_i    (rd_ack_i),
  .wr_ack_i    (wr_ack_i),
  .ptr_o       (ptr_o),
  .cnt_we_o    (cnt_we_o),
  .cnt_wdata_o (cnt_wdata_o)
);

// File: tb/tb_rtc_shadow_buffer.sv
`timescale 1ns/1ps
module tb_rtc_shadow_buffer;
  localparam int NREGS = 7;
  localparam int DW    = 8;
  localparam int AW    = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start_i = 0, stop_i = 0, ptr_load_i = 0, rd_ack_i = 0, wr_ack_i = 0;
  logic [DW-1:0]       ptr_val_i = '0, wr_data_i = '0;
  logic [NREGS*DW-1:0] live_i = '0;
  logic [AW-1:0]       ptr_o;
  logic [DW-1:0]       rd_data_o;
  logic [NREGS-1:0]    cnt_we_o;
  logic [DW-1:0]       cnt_wdata_o;

  always #2 clk = ~clk;

  rtc_shadow_buffer #(.NREGS(NREGS), .DW(DW)) dut (.*);

  int    n_cmp = 0, n_bad = 0;
  string phase = "R1";
  bit    started = 0, done = 0;

  // behavioural reference state
  int               m_ptr;
  byte unsigned     m_copy [NREGS];
  byte unsigned     m_rd, m_wd;
  logic [NREGS-1:0] m_we;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_ptr = 0; m_rd = 0; m_wd = 0; m_we = '0;
      foreach (m_copy[k]) m_copy[k] = 0;
    end else begin
      int nxt;
      bit wrapped;
      m_rd = m_copy[m_ptr];
      m_we = wr_ack_i ? (NREGS'(1) << m_ptr) : '0;
      m_wd = wr_ack_i ? wr_data_i : 8'd0;
      wrapped = 0;
      nxt = m_ptr;
      if (ptr_load_i) nxt = (int'(ptr_val_i) < NREGS) ? int'(ptr_val_i) : 0;
      else if (rd_ack_i || wr_ack_i) begin
        if (m_ptr == NREGS - 1) begin nxt = 0; wrapped = 1; end
        else nxt = m_ptr + 1;
      end
      if (start_i || stop_i || wrapped)
        foreach (m_copy[k]) m_copy[k] = live_i[k*DW +: DW];
      if (wr_ack_i) m_copy[m_ptr] = wr_data_i;
      m_ptr = nxt;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [phase %s] actual=%0h expected=%0h", what, phase, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk(int'(ptr_o) == m_ptr, "R4 ptr_o", int'(ptr_o), m_ptr);
    chk(rd_data_o == m_rd, "R10 rd_data_o", int'(rd_data_o), int'(m_rd));
    chk(cnt_we_o == m_we, "R7 cnt_we_o", int'(cnt_we_o), int'(m_we));
    chk(cnt_wdata_o == m_wd, "R7 cnt_wdata_o", int'(cnt_wdata_o), int'(m_wd));
  end

  task automatic drive(input bit s, input bit p, input bit ld, input int v,
                       input bit ra, input bit wa, input int wd);
    @(negedge clk);
    start_i = s; stop_i = p; ptr_load_i = ld; ptr_val_i = DW'(v);
    rd_ack_i = ra; wr_ack_i = wa; wr_data_i = DW'(wd);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic set_live(input int base);
    for (int k = 0; k < NREGS; k++) live_i[k*DW +: DW] = DW'(base + k * 17);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (4) @(negedge clk);
    phase = "R1";
    chk(ptr_o == '0 && rd_data_o == '0 && cnt_we_o == '0 && cnt_wdata_o == '0,
        "R1 reset outputs", int'(rd_data_o), 0);
    rst = 0;
    idle(2);

    phase = "R2";
    set_live(8'h10);
    drive(1, 0, 0, 0, 0, 0, 0);
    idle(2);
    phase = "R6";
    for (int i = 0; i < NREGS - 1; i++) begin
      set_live(8'h40 + i);
      drive(0, 0, 0, 0, 1, 0, 0);
      idle(1);
    end
    phase = "R5";
    set_live(8'h90);
    drive(0, 0, 0, 0, 1, 0, 0);
    set_live(8'hC0);
    idle(3);
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 1, 0, 0);
    idle(2);

    phase = "R3";
    set_live(8'h21);
    drive(0, 1, 0, 0, 0, 0, 0);
    set_live(8'h55);
    idle(2);
    drive(0, 0, 1, 0, 0, 0, 0);
    idle(2);

    phase = "R9";
    drive(0, 0, 1, 3, 0, 0, 0);
    idle(2);
    drive(0, 0, 1, 200, 0, 0, 0);
    idle(2);
    drive(0, 0, 1, NREGS, 0, 0, 0);
    idle(2);

    phase = "R7";
    drive(0, 0, 1, 4, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1, 8'hA4);
    drive(0, 0, 0, 0, 0, 1, 8'hA5);
    phase = "R8";
    set_live(8'h77);
    drive(1, 0, 0, 0, 0, 1, 8'hA6);
    idle(2);
    drive(0, 0, 1, 6, 0, 0, 0);
    idle(2);
    drive(0, 0, 1, 4, 0, 0, 0);
    idle(2);

    phase = "mix";
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      int sel;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sel = int'(lfsr[3:0]);
      set_live(int'(lfsr[15:8]));
      drive(sel == 6 || sel == 8, sel == 7 || sel == 8,
            sel == 9, int'(lfsr[11:4]) % 12,
            sel < 4, sel == 4 || sel == 5, int'(lfsr[15:8]));
    end
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog [phase %s] actual=hung expected=finished", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule